// File: doc/BRIEF.md
# Runtime-Configurable Cache Tag Timing Model

This block models the timing of private caches for several simulated cores while holding no cache data at all. For every core it keeps a tag store of valid bits, dirty bits, tags and per-set recency state. Each lookup carries a core number, a byte address and a read/write flag. The block answers with a hit or a miss, reports which way was hit or filled, and flags a writeback with the line address of the victim when a dirty line is evicted.

The storage is sized at build time for the largest geometry: the most sets, the longest line and the most ways. At runtime a configuration write selects a smaller geometry without rebuilding the block. The set index is taken from the address shifted right by the programmed line-size exponent and masked to the programmed set count. Ways at or above the programmed way count are switched off. With the default parameters the largest geometry is a 32 KB, 4-way cache with 128-byte lines for each core.

Top module: `cache_tag_model`

## Requirements
- R1: After reset every entry is invalid, the event outputs are low and the geometry is the largest one, so the first lookup misses.
- R2: A lookup accepted at a clock edge raises exactly one of hit_o or miss_o for the following cycle. With no accepted lookup, hit_o, miss_o and wb_o stay low.
- R3: The line address is the request address shifted right by the line-size exponent, and the set is that line address ANDed with (2^sets_log2 - 1). Two addresses in the same line hit each other.
- R4: All enabled ways of the selected set are compared in the same cycle. A valid entry whose stored line address matches gives a hit, and way_o reports that way.
- R5: A way whose index is equal to or greater than the programmed way count never hits and is never filled.
- R6: On a miss, the lowest-numbered invalid enabled way is filled. If every enabled way is valid, the least recently used enabled way is filled. way_o reports the filled way.
- R7: A write marks the accessed line dirty. A read miss fills a clean line. Evicting a valid dirty line raises wb_o together with miss_o, and wb_addr_o carries the victim line address shifted left by the line-size exponent.
- R8: A configuration write invalidates every entry of every core. A lookup presented in the same cycle produces no event, and the next lookup misses.
- R9: Configuration values are clamped: a set exponent above the maximum becomes the maximum, a line exponent becomes the nearest value in the built range, and a way count of 0 becomes 1 while a count above the maximum becomes the maximum.
- R10: Each core has its own sets. A line cached for one core does not hit for another core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sets_log2_i | input | SL_W | log2 of the set count |
| cfg_blk_log2_i | input | BL_W | log2 of the line size in bytes |
| cfg_ways_i | input | WCNT_W | Number of enabled ways |
| req_valid_i | input | 1 | Lookup request |
| req_core_i | input | CORE_W | Core number of the lookup |
| req_addr_i | input | ADDR_W | Byte address of the lookup |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| hit_o | output | 1 | Hit pulse |
| miss_o | output | 1 | Miss pulse |
| wb_o | output | 1 | Dirty-victim writeback pulse |
| wb_addr_o | output | ADDR_W | Line base address of the evicted line |
| way_o | output | WAY_W | Way that was hit or filled |

## Verification
The result of every lookup is registered at the edge that accepts the request, so hit_o, miss_o, wb_o, wb_addr_o and way_o are due exactly one cycle later. The tags, dirty bits and recency state are also updated at that edge, so back-to-back lookups to the same set see each other. The bench drives each request on a falling edge and compares all outputs at the next falling edge against a reference model that uses use-time stamps. That one-cycle check is repeated for every configuration in a sweep over set exponents, line exponents and way counts, including out-of-range values. A configuration write is checked the same way: no event in the following cycle, and a miss for the next lookup.

// File: rtl/tagsim_pkg.sv
package tagsim_pkg;
  typedef struct packed {
    logic hit;
    logic miss;
    logic wb;
  } evt_t;
endpackage

// File: rtl/tagsim_cfg.sv
module tagsim_cfg #(
  parameter int MAX_SETS_LOG2 = 6,
  parameter int MIN_BLK_LOG2  = 5,
  parameter int MAX_BLK_LOG2  = 7,
  parameter int MAX_WAYS      = 4,
  parameter int SL_W          = 3,
  parameter int BL_W          = 3,
  parameter int WCNT_W        = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SL_W-1:0]   sets_log2_i,
  input  logic [BL_W-1:0]   blk_log2_i,
  input  logic [WCNT_W-1:0] ways_i,
  output logic [SL_W-1:0]   sets_log2_o,
  output logic [BL_W-1:0]   blk_log2_o,
  output logic [WCNT_W-1:0] ways_o
);
  localparam logic [SL_W-1:0]   SL_MAX = SL_W'(MAX_SETS_LOG2);
  localparam logic [BL_W-1:0]   BL_MIN = BL_W'(MIN_BLK_LOG2);
  localparam logic [BL_W-1:0]   BL_MAX = BL_W'(MAX_BLK_LOG2);
  localparam logic [WCNT_W-1:0] W_MAX  = WCNT_W'(MAX_WAYS);

  logic [SL_W-1:0]   sl_c;
  logic [BL_W-1:0]   bl_c;
  logic [WCNT_W-1:0] w_c;

  always_comb begin
    sl_c = (sets_log2_i > SL_MAX) ? SL_MAX : sets_log2_i;
    bl_c = (blk_log2_i < BL_MIN) ? BL_MIN :
           (blk_log2_i > BL_MAX) ? BL_MAX : blk_log2_i;
    w_c  = (ways_i == '0) ? WCNT_W'(1) :
           (ways_i > W_MAX) ? W_MAX : ways_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sets_log2_o <= SL_MAX;
      blk_log2_o  <= BL_MAX;
      ways_o      <= W_MAX;
    end else if (we_i) begin
      sets_log2_o <= sl_c;
      blk_log2_o  <= bl_c;
      ways_o      <= w_c;
    end
  end
endmodule

// File: rtl/tagsim_index.sv
module tagsim_index #(
  parameter int ADDR_W        = 32,
  parameter int MAX_SETS_LOG2 = 6,
  parameter int CORE_W        = 2,
  parameter int SL_W          = 3,
  parameter int BL_W          = 3,
  parameter int TAG_W         = 27
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [CORE_W-1:0]               core_i,
  input  logic [SL_W-1:0]                 sets_log2_i,
  input  logic [BL_W-1:0]                 blk_log2_i,
  output logic [CORE_W+MAX_SETS_LOG2-1:0] row_o,
  output logic [TAG_W-1:0]                tag_o
);
  logic [MAX_SETS_LOG2-1:0] set_mask;
  logic [MAX_SETS_LOG2-1:0] set_idx;

  // full line address kept as tag: valid for the smallest set count
  assign tag_o    = TAG_W'(addr_i >> blk_log2_i);
  assign set_mask = ~({MAX_SETS_LOG2{1'b1}} << sets_log2_i);
  assign set_idx  = MAX_SETS_LOG2'(addr_i >> blk_log2_i) & set_mask;
  assign row_o    = {core_i, set_idx};
endmodule

// File: rtl/tagsim_match.sv
module tagsim_match #(
  parameter int MAX_WAYS = 4,
  parameter int TAG_W    = 27,
  parameter int WAY_W    = 2,
  parameter int WCNT_W   = 3
) (
  input  logic [MAX_WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [MAX_WAYS-1:0]            valid_i,
  input  logic [WCNT_W-1:0]              ways_i,
  input  logic [TAG_W-1:0]               tag_i,
  output logic [MAX_WAYS-1:0]            en_o,
  output logic                           hit_o,
  output logic [WAY_W-1:0]               hit_way_o
);
  logic [MAX_WAYS-1:0] hit_vec;

  for (genvar w = 0; w < MAX_WAYS; w++) begin : g_way
    assign en_o[w]    = (WCNT_W'(w) < ways_i);
    assign hit_vec[w] = en_o[w] & valid_i[w] & (tags_i[w] == tag_i);
  end

  always_comb begin
    hit_o     = |hit_vec;
    hit_way_o = '0;
    for (int w = MAX_WAYS - 1; w >= 0; w--)
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
  end
endmodule

// File: rtl/tagsim_victim.sv
module tagsim_victim #(
  parameter int MAX_WAYS = 4,
  parameter int WAY_W    = 2
) (
  input  logic [MAX_WAYS-1:0]            en_i,
  input  logic [MAX_WAYS-1:0]            valid_i,
  input  logic [MAX_WAYS-1:0][WAY_W-1:0] age_i,
  output logic [WAY_W-1:0]               victim_o
);
  logic             found;
  logic [WAY_W-1:0] oldest;

  always_comb begin
    found    = 1'b0;
    oldest   = '0;
    victim_o = '0;
    for (int w = 0; w < MAX_WAYS; w++) begin
      if (en_i[w] && !valid_i[w] && !found) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < MAX_WAYS; w++) begin
        if (en_i[w] && age_i[w] >= oldest) begin
          oldest   = age_i[w];
          victim_o = WAY_W'(w);
        end
      end
    end
  end
endmodule

// File: rtl/cache_tag_model.sv
module cache_tag_model
  import tagsim_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int ADDR_W        = 32,
  parameter int MAX_SETS_LOG2 = 6,
  parameter int MAX_WAYS      = 4,
  parameter int MIN_BLK_LOG2  = 5,
  parameter int MAX_BLK_LOG2  = 7,
  localparam int CORE_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int WAY_W        = (MAX_WAYS > 1) ? $clog2(MAX_WAYS) : 1,
  localparam int WCNT_W       = $clog2(MAX_WAYS + 1),
  localparam int SL_W         = $clog2(MAX_SETS_LOG2 + 1),
  localparam int BL_W         = $clog2(MAX_BLK_LOG2 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SL_W-1:0]   cfg_sets_log2_i,
  input  logic [BL_W-1:0]   cfg_blk_log2_i,
  input  logic [WCNT_W-1:0] cfg_ways_i,
  input  logic              req_valid_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic              wb_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [WAY_W-1:0]  way_o
);
  localparam int TAG_W = ADDR_W - MIN_BLK_LOG2;
  localparam int ROW_W = CORE_W + MAX_SETS_LOG2;
  localparam int ROWS  = 1 << ROW_W;

  logic [SL_W-1:0]   act_sets_log2;
  logic [BL_W-1:0]   act_blk_log2;
  logic [WCNT_W-1:0] act_ways;

  tagsim_cfg #(
    .MAX_SETS_LOG2(MAX_SETS_LOG2), .MIN_BLK_LOG2(MIN_BLK_LOG2),
    .MAX_BLK_LOG2(MAX_BLK_LOG2), .MAX_WAYS(MAX_WAYS),
    .SL_W(SL_W), .BL_W(BL_W), .WCNT_W(WCNT_W)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .sets_log2_i(cfg_sets_log2_i), .blk_log2_i(cfg_blk_log2_i), .ways_i(cfg_ways_i),
    .sets_log2_o(act_sets_log2), .blk_log2_o(act_blk_log2), .ways_o(act_ways)
  );

  logic [ROW_W-1:0] row;
  logic [TAG_W-1:0] tag;

  tagsim_index #(
    .ADDR_W(ADDR_W), .MAX_SETS_LOG2(MAX_SETS_LOG2), .CORE_W(CORE_W),
    .SL_W(SL_W), .BL_W(BL_W), .TAG_W(TAG_W)
  ) u_idx (
    .addr_i(req_addr_i), .core_i(req_core_i),
    .sets_log2_i(act_sets_log2), .blk_log2_i(act_blk_log2),
    .row_o(row), .tag_o(tag)
  );

  // metadata store: tags, valid, dirty, recency age (0 = newest)
  logic [MAX_WAYS-1:0][TAG_W-1:0] tag_q   [ROWS];
  logic [MAX_WAYS-1:0]            valid_q [ROWS];
  logic [MAX_WAYS-1:0]            dirty_q [ROWS];
  logic [MAX_WAYS-1:0][WAY_W-1:0] age_q   [ROWS];

  logic [MAX_WAYS-1:0][TAG_W-1:0] row_tags;
  logic [MAX_WAYS-1:0]            row_valid;
  logic [MAX_WAYS-1:0]            row_dirty;
  logic [MAX_WAYS-1:0][WAY_W-1:0] row_age;

  assign row_tags  = tag_q[row];
  assign row_valid = valid_q[row];
  assign row_dirty = dirty_q[row];
  assign row_age   = age_q[row];

  logic [MAX_WAYS-1:0] way_en;
  logic                hit;
  logic [WAY_W-1:0]    hit_way;
  logic [WAY_W-1:0]    victim;

  tagsim_match #(
    .MAX_WAYS(MAX_WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W), .WCNT_W(WCNT_W)
  ) u_match (
    .tags_i(row_tags), .valid_i(row_valid), .ways_i(act_ways), .tag_i(tag),
    .en_o(way_en), .hit_o(hit), .hit_way_o(hit_way)
  );

  tagsim_victim #(
    .MAX_WAYS(MAX_WAYS), .WAY_W(WAY_W)
  ) u_vict (
    .en_i(way_en), .valid_i(row_valid), .age_i(row_age), .victim_o(victim)
  );

  logic                           accept;
  logic [WAY_W-1:0]               way_sel;
  logic [MAX_WAYS-1:0][WAY_W-1:0] age_nxt;

  assign accept  = req_valid_i & ~cfg_we_i;
  assign way_sel = hit ? hit_way : victim;

  always_comb begin
    for (int w = 0; w < MAX_WAYS; w++) begin
      if (WAY_W'(w) == way_sel)             age_nxt[w] = '0;
      else if (row_age[w] < row_age[way_sel]) age_nxt[w] = row_age[w] + 1'b1;
      else                                  age_nxt[w] = row_age[w];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) begin
        valid_q[r] <= '0;
        dirty_q[r] <= '0;
        for (int w = 0; w < MAX_WAYS; w++) age_q[r][w] <= WAY_W'(w);
      end
    end else if (cfg_we_i) begin
      for (int r = 0; r < ROWS; r++) begin
        valid_q[r] <= '0;
        dirty_q[r] <= '0;
        for (int w = 0; w < MAX_WAYS; w++) age_q[r][w] <= WAY_W'(w);
      end
    end else if (accept) begin
      valid_q[row][way_sel] <= 1'b1;
      dirty_q[row][way_sel] <= hit ? (row_dirty[way_sel] | req_write_i) : req_write_i;
      age_q[row]            <= age_nxt;
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept && !hit) tag_q[row][way_sel] <= tag;
  end

  evt_t             evt_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [WAY_W-1:0]  way_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q     <= '0;
      wb_addr_q <= '0;
      way_q     <= '0;
    end else begin
      evt_q.hit  <= accept & hit;
      evt_q.miss <= accept & ~hit;
      evt_q.wb   <= accept & ~hit & row_valid[victim] & row_dirty[victim];
      wb_addr_q  <= ADDR_W'(row_tags[victim]) << act_blk_log2;
      way_q      <= way_sel;
    end
  end

  assign hit_o     = evt_q.hit;
  assign miss_o    = evt_q.miss;
  assign wb_o      = evt_q.wb;
  assign wb_addr_o = wb_addr_q;
  assign way_o     = way_q;
endmodule

// File: rtl/cache_tag_model_chk.sv
module cache_tag_model_chk #(
  parameter int WAY_W  = 2,
  parameter int WCNT_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              req_valid_i,
  input logic              hit_o,
  input logic              miss_o,
  input logic              wb_o,
  input logic [WAY_W-1:0]  way_o,
  input logic [WCNT_W-1:0] ways_i
);
  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !cfg_we_i) |=> (hit_o ^ miss_o)); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !cfg_we_i) |=> !(hit_o || miss_o || wb_o)); // R8
  AST_WB_WITH_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> miss_o); // R7
  AST_WAY_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o || miss_o) |-> (WCNT_W'(way_o) < ways_i)); // R5
  AST_FLUSH_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_we_i) && req_valid_i && !cfg_we_i) |=> miss_o); // R8
endmodule

bind cache_tag_model cache_tag_model_chk #(.WAY_W(WAY_W), .WCNT_W(WCNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .req_valid_i(req_valid_i),
  .hit_o(hit_o), .miss_o(miss_o), .wb_o(wb_o), .way_o(way_o), .ways_i(act_ways)
);

// File: tb/cache_tag_model_bench.sv
module cache_tag_model_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC   = 2;
  localparam int AW   = 12;
  localparam int MSL  = 2;
  localparam int MW   = 4;
  localparam int MINB = 2;
  localparam int MAXB = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_sets_log2_i = '0;
  logic [2:0]    cfg_blk_log2_i = '0;
  logic [2:0]    cfg_ways_i = '0;
  logic          req_valid_i = 1'b0;
  logic [0:0]    req_core_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic          req_write_i = 1'b0;
  logic          hit_o, miss_o, wb_o;
  logic [AW-1:0] wb_addr_o;
  logic [1:0]    way_o;

  cache_tag_model #(
    .NUM_CORES(NC), .ADDR_W(AW), .MAX_SETS_LOG2(MSL), .MAX_WAYS(MW),
    .MIN_BLK_LOG2(MINB), .MAX_BLK_LOG2(MAXB)
  ) u_cache_tag_model (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model, recency tracked by use-time stamps
  bit mv [NC][1<<MSL][MW];
  bit md [NC][1<<MSL][MW];
  int mt [NC][1<<MSL][MW];
  int ms [NC][1<<MSL][MW];
  int c_sl, c_bl, c_w, now;
  int unsigned seed = 32'h1234_5678;

  task automatic check(string rq, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic void model_clear();
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < (1 << MSL); s++)
        for (int w = 0; w < MW; w++) begin
          mv[c][s][w] = 0; md[c][s][w] = 0; ms[c][s][w] = 0;
        end
  endfunction

  // drive at a falling edge, results due at the next falling edge
  task automatic lookup(int core, int addr, bit wr, string rq);
    int set, tag, hw, vw, mn, ewb, ewba;
    bit eh;
    req_valid_i = 1'b1;
    req_core_i  = core[0:0];
    req_addr_i  = addr[AW-1:0];
    req_write_i = wr;
    set = (addr >> c_bl) & ((1 << c_sl) - 1);
    tag = addr >> c_bl;
    hw = -1;
    for (int w = 0; w < c_w; w++)
      if (mv[core][set][w] && mt[core][set][w] == tag) hw = w;
    eh = (hw >= 0);
    ewb = 0; ewba = 0;
    if (eh) begin
      vw = hw;
      md[core][set][vw] |= wr;
    end else begin
      vw = -1;
      for (int w = c_w - 1; w >= 0; w--) if (!mv[core][set][w]) vw = w;
      if (vw < 0) begin
        mn = 32'h7fff_ffff;
        for (int w = 0; w < c_w; w++)
          if (ms[core][set][w] < mn) begin mn = ms[core][set][w]; vw = w; end
      end
      ewb  = mv[core][set][vw] && md[core][set][vw];
      ewba = (mt[core][set][vw] << c_bl) & ((1 << AW) - 1);
      mv[core][set][vw] = 1; md[core][set][vw] = wr; mt[core][set][vw] = tag;
    end
    ms[core][set][vw] = ++now;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(rq, hit_o, eh);
    check("R2", miss_o, !eh);
    check("R6", way_o, vw);
    check("R7", wb_o, ewb);
    if (ewb) check("R7", wb_addr_o, ewba);
  endtask

  task automatic cfg(int sl, int bl, int w, bit with_req);
    cfg_we_i        = 1'b1;
    cfg_sets_log2_i = sl[1:0];
    cfg_blk_log2_i  = bl[2:0];
    cfg_ways_i      = w[2:0];
    req_valid_i     = with_req;
    req_addr_i      = AW'(rnd());
    @(negedge clk_i);
    cfg_we_i    = 1'b0;
    req_valid_i = 1'b0;
    check("R8", hit_o | miss_o | wb_o, 0);
    c_sl = (sl > MSL) ? MSL : sl;
    c_bl = (bl < MINB) ? MINB : (bl > MAXB) ? MAXB : bl;
    c_w  = (w == 0) ? 1 : (w > MW) ? MW : w;
    model_clear();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    c_sl = MSL; c_bl = MAXB; c_w = MW; now = 0;
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", hit_o | miss_o | wb_o, 0);
    lookup(0, 'h40, 0, "R1");
    lookup(0, 'h4C, 1, "R3");   // same 16-byte line
    check("R3", hit_o, 1);
    lookup(1, 'h40, 0, "R10");  // other core: miss
    check("R10", miss_o, 1);

    // two ways, three conflicting lines in one set
    cfg(0, 2, 2, 1'b1);
    lookup(0, 'h00, 1, "R8");
    check("R8", miss_o, 1);
    lookup(0, 'h04, 0, "R5");
    lookup(0, 'h08, 0, "R5");
    check("R5", way_o, 0);
    check("R7", wb_o, 1);
    check("R7", wb_addr_o, 'h00);

    // way count 0 clamps to one way
    cfg(3, 7, 0, 1'b0);
    lookup(0, 'h10, 0, "R9");
    lookup(0, 'h110, 0, "R9");
    lookup(0, 'h10, 0, "R9");
    check("R9", miss_o, 1);

    // sweep geometry, including out-of-range values
    for (int sl = 0; sl < 4; sl++)
      for (int bl = 1; bl < 6; bl++)
        for (int w = 0; w < 6; w++) begin
          cfg(sl, bl, w, (sl + w) % 2 == 1);
          for (int k = 0; k < 48; k++) begin
            int unsigned r = rnd();
            int span = (c_w + 2) << (c_sl + c_bl);
            lookup(int'(r[0]), int'((r >> 2) % span), r[1], "R4");
          end
        end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule